// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Serializer

This block produces the fixed answer that a memory card returns when its reset pin is pulsed. A pulse on the reset pin that has a falling serial-clock edge inside it arms the block. When the pin returns low, the first answer bit goes out on the serial data line. Each later falling edge of the serial clock moves the line to the next bit. After the last of the 32 bits the block releases the line and drops back to standby.

All pins are sampled on the block's own clock through a parameterised synchroniser, and edges are found on the synchronised copies. The block does not start an answer while the card's nonvolatile write cycle is running, which is signalled on a busy input. A power-fail input aborts any answer or pulse in progress. A new reset pulse during an answer restarts it from the first bit when a clock edge falls inside that pulse. Without such an edge, the new pulse aborts the answer.

Top module: `rst_answer_ser`

## Requirements
- R1: After the synchronous reset, the output enable is low and the data output is high (line released).
- R2: A reset-pin pulse with at least one falling serial-clock edge inside it, while busy and power-fail are low, leaves the output enable high with answer bit 0 on the data output once the pin is low again.
- R3: Answer bit i is bit (i mod 8) of answer byte (i div 8), so byte 0 goes first and each byte goes least significant bit first. The default bytes are 19h, 02h, AAh, 55h for bytes 0 to 3.
- R4: While answering with the reset pin low, each falling serial-clock edge moves the output to the next bit, and a rising edge changes nothing.
- R5: The falling clock edge during bit 31 ends the answer and sets the output enable low. Further clock edges drive nothing.
- R6: A reset-pin pulse with no falling clock edge inside it produces no answer.
- R7: During an answer, a new reset-pin pulse with a falling clock edge inside it restarts the answer at bit 0.
- R8: During an answer, a new reset-pin pulse with no falling clock edge inside it aborts the answer and the output enable goes low.
- R9: When the busy input is high as the reset pin returns low, no answer starts.
- R10: Power-fail high sets the output enable low and discards an answer or pulse in progress. A pulse that was under way when it arrived gives no answer.
- R11: While the synchronised reset pin is high, the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_i | input | 1 | Card reset pin level |
| sclk_i | input | 1 | Serial clock pin level |
| wr_busy_i | input | 1 | High while a nonvolatile write cycle runs |
| pwr_fail_i | input | 1 | Power-interruption abort |
| sd_o | output | 1 | Serial data bit, high when released |
| sd_oe_o | output | 1 | High while a bit is being driven |

## Verification
A full answer is read out and compared bit by bit with the byte values. This separates bit-order errors and byte-order errors from ROM content errors. A restart pulse and an abort pulse are each swept over every one of the 32 bit positions. This shows whether the restart-or-abort decision depends only on the clock edge inside the pulse, and not on how far the answer had progressed. Pulses without a clock edge, and pulses with busy or power-fail raised, separate the suppression paths from the start path. Extra clock pulses after the last bit, and rising-edge-only activity, show whether standby and bit advance key on the right edge.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } rsa_state_e;
endpackage

// File: rtl/rsa_sync.sv
module rsa_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsa_rom.sv
module rsa_rom #(
  parameter int                  NBITS  = 32,
  parameter int                  IDXW   = 5,
  parameter logic [NBITS-1:0]    ANSWER = '0
) (
  input  logic [IDXW-1:0] idx,
  output logic            bit_o
);
  // Byte 0 sits in ANSWER[7:0]; bit i is sent i-th, which gives byte order and LSB-first order.
  always_comb begin
    bit_o = 1'b1;
    for (int i = 0; i < NBITS; i++) begin
      if (idx == IDXW'(i)) bit_o = ANSWER[i];
    end
  end
endmodule

// File: rtl/rsa_seq.sv
module rsa_seq
  import rsa_pkg::*;
#(
  parameter int NBITS = 32,
  parameter int IDXW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rst_s,
  input  logic            sclk_s,
  input  logic            wr_busy,
  input  logic            pwr_fail,
  output logic            send_nx,
  output logic [IDXW-1:0] idx_nx,
  output logic [IDXW-1:0] idx_q,
  output logic            ovl_q
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NBITS - 1);

  rsa_state_e state_q, state_nx;
  logic       ovl_nx;
  logic       rst_d, sclk_d;
  logic       rst_rise, rst_fall, sclk_fall;

  assign rst_rise  = rst_s & ~rst_d;
  assign rst_fall  = ~rst_s & rst_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  always_comb begin
    state_nx = state_q;
    idx_nx   = idx_q;
    ovl_nx   = ovl_q;
    if (pwr_fail) begin
      state_nx = ST_IDLE;
      idx_nx   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rst_rise) begin
            state_nx = ST_ARMED;
            ovl_nx   = 1'b0;
          end
        end
        ST_ARMED: begin
          if (rst_fall) begin
            idx_nx   = '0;
            state_nx = (ovl_q && !wr_busy) ? ST_SEND : ST_IDLE;
          end else if (sclk_fall) begin
            ovl_nx = 1'b1;
          end
        end
        ST_SEND: begin
          if (rst_rise) begin
            state_nx = ST_ARMED;
            ovl_nx   = 1'b0;
          end else if (sclk_fall && !rst_s) begin
            if (idx_q == LAST) begin
              state_nx = ST_IDLE;
              idx_nx   = '0;
            end else begin
              idx_nx = idx_q + 1'b1;
            end
          end
        end
        default: state_nx = ST_IDLE;
      endcase
    end
    if (state_nx != ST_ARMED) ovl_nx = 1'b0;
  end

  assign send_nx = (state_nx == ST_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ovl_q   <= 1'b0;
      rst_d   <= 1'b0;
      sclk_d  <= 1'b0;
    end else begin
      state_q <= state_nx;
      idx_q   <= idx_nx;
      ovl_q   <= ovl_nx;
      rst_d   <= rst_s;
      sclk_d  <= sclk_s;
    end
  end
endmodule

// File: rtl/rst_answer_ser.sv
module rst_answer_ser #(
  parameter int                    NBYTES      = 4,
  parameter logic [8*NBYTES-1:0]   ANSWER      = 32'h55AA_0219,
  parameter int                    SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_pin_i,
  input  logic sclk_i,
  input  logic wr_busy_i,
  input  logic pwr_fail_i,
  output logic sd_o,
  output logic sd_oe_o
);
  localparam int NBITS = 8 * NBYTES;
  localparam int IDXW  = $clog2(NBITS);

  logic [1:0]      pins_s;
  logic            rst_s, sclk_s;
  logic            send_nx, ovl_q, rom_bit;
  logic [IDXW-1:0] idx_nx, bit_idx;

  rsa_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({rst_pin_i, sclk_i}), .q(pins_s)
  );
  assign rst_s  = pins_s[1];
  assign sclk_s = pins_s[0];

  rsa_seq #(.NBITS(NBITS), .IDXW(IDXW)) u_seq (
    .clk(clk), .rst(rst), .rst_s(rst_s), .sclk_s(sclk_s),
    .wr_busy(wr_busy_i), .pwr_fail(pwr_fail_i),
    .send_nx(send_nx), .idx_nx(idx_nx), .idx_q(bit_idx), .ovl_q(ovl_q)
  );

  rsa_rom #(.NBITS(NBITS), .IDXW(IDXW), .ANSWER(ANSWER)) u_rom (
    .idx(idx_nx), .bit_o(rom_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_oe_o <= 1'b0;
      sd_o    <= 1'b1;
    end else begin
      sd_oe_o <= send_nx;
      sd_o    <= send_nx ? rom_bit : 1'b1;
    end
  end
endmodule

// File: rtl/rsa_chk.sv
module rsa_chk #(
  parameter int IDXW = 5,
  parameter int LAST = 31
) (
  input logic            clk,
  input logic            rst,
  input logic            rst_s,
  input logic            sclk_s,
  input logic            wr_busy,
  input logic            pwr_fail,
  input logic            ovl,
  input logic [IDXW-1:0] idx,
  input logic            oe
);
  // R10
  pwr_release_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> !oe);
  // R11
  pulse_release_chk: assert property (@(posedge clk) disable iff (rst)
    rst_s |=> !oe);
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_s) && wr_busy) |=> !oe);
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_s) && ovl && !wr_busy && !pwr_fail) |=> (oe && idx == '0));
  // R4
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && !rst_s && !pwr_fail && $fell(sclk_s) && idx != IDXW'(LAST))
      |=> (oe && idx == $past(idx) + 1'b1));
  // R5
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && !rst_s && !pwr_fail && $fell(sclk_s) && idx == IDXW'(LAST)) |=> !oe);
endmodule

bind rst_answer_ser rsa_chk #(.IDXW(IDXW), .LAST(NBITS - 1)) u_chk (
  .clk(clk), .rst(rst), .rst_s(rst_s), .sclk_s(sclk_s),
  .wr_busy(wr_busy_i), .pwr_fail(pwr_fail_i),
  .ovl(ovl_q), .idx(bit_idx), .oe(sd_oe_o)
);

// File: tb/tb_rst_answer_ser.sv
module tb_rst_answer_ser;
  logic clk = 1'b0, rst = 1'b1;
  logic rst_pin = 1'b0, sclk = 1'b0, busy = 1'b0, pwr = 1'b0;
  logic sd, oe;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  rst_answer_ser dut (
    .clk(clk), .rst(rst), .rst_pin_i(rst_pin), .sclk_i(sclk),
    .wr_busy_i(busy), .pwr_fail_i(pwr), .sd_o(sd), .sd_oe_o(oe)
  );

  function automatic logic exp_bit(int i);
    logic [7:0] b;
    case (i / 8)
      0: b = 8'h19;
      1: b = 8'h02;
      2: b = 8'hAA;
      default: b = 8'h55;
    endcase
    return b[i % 8];
  endfunction

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    sclk = 1'b1; settle();
    sclk = 1'b0; settle();
  endtask

  task automatic pulse(bit with_clk);
    rst_pin = 1'b1; settle();
    if (with_clk) tick();
    rst_pin = 1'b0; settle();
  endtask

  task automatic chk(string req, logic act_oe, logic act_sd, logic e_oe, logic e_sd);
    checks++;
    if (act_oe !== e_oe || (e_oe && act_sd !== e_sd)) begin
      errors++;
      $display("FAIL %s: oe=%b sd=%b expected oe=%b sd=%b", req, act_oe, act_sd, e_oe, e_sd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", oe, sd, 1'b0, 1'b1);
    checks++;
    if (sd !== 1'b1) begin errors++; $display("FAIL R1: sd=%b expected 1", sd); end
    rst = 1'b0; settle();

    // R6: pulse without clock
    pulse(1'b0);
    chk("R6", oe, sd, 1'b0, 1'b1);

    // R2, R3, R4, R5: full answer
    pulse(1'b1);
    chk("R2", oe, sd, 1'b1, exp_bit(0));
    for (int i = 0; i < 32; i++) begin
      chk("R3", oe, sd, 1'b1, exp_bit(i));
      sclk = 1'b1; settle();
      chk("R4", oe, sd, 1'b1, exp_bit(i));  // rising edge does not advance
      sclk = 1'b0; settle();
    end
    chk("R5", oe, sd, 1'b0, 1'b1);
    tick(); tick();
    chk("R5", oe, sd, 1'b0, 1'b1);

    // R7, R11: restart swept over every position
    for (int k = 0; k < 32; k++) begin
      pulse(1'b1);
      for (int j = 0; j < k; j++) tick();
      chk("R4", oe, sd, 1'b1, exp_bit(k));
      rst_pin = 1'b1; settle();
      chk("R11", oe, sd, 1'b0, 1'b1);
      tick();
      rst_pin = 1'b0; settle();
      chk("R7", oe, sd, 1'b1, exp_bit(0));
      tick();
      chk("R7", oe, sd, 1'b1, exp_bit(1));
      pwr = 1'b1; settle(); pwr = 1'b0; settle();
    end

    // R8: abort swept over every position
    for (int k = 0; k < 32; k++) begin
      pulse(1'b1);
      for (int j = 0; j < k; j++) tick();
      pulse(1'b0);
      chk("R8", oe, sd, 1'b0, 1'b1);
      tick();
      chk("R8", oe, sd, 1'b0, 1'b1);
    end

    // R9: busy suppresses start
    busy = 1'b1;
    pulse(1'b1);
    chk("R9", oe, sd, 1'b0, 1'b1);
    busy = 1'b0;
    pulse(1'b1);
    chk("R9", oe, sd, 1'b1, exp_bit(0));

    // R10: power fail mid-answer, then during a pulse
    tick(); tick(); tick();
    pwr = 1'b1; settle();
    chk("R10", oe, sd, 1'b0, 1'b1);
    pwr = 1'b0; settle(); tick();
    chk("R10", oe, sd, 1'b0, 1'b1);
    rst_pin = 1'b1; settle();
    pwr = 1'b1; settle();
    tick();
    pwr = 1'b0; settle();
    rst_pin = 1'b0; settle();
    chk("R10", oe, sd, 1'b0, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule